// File: doc/BRIEF.md
# Serial Transmit Engine with Eighth-Bit Stop Control

This block turns one character at a time into an asynchronous serial frame on a single output line. A character of five to eight data bits is taken through a valid/ready handshake and sent as a low start bit, the data bits least significant first, an optional parity bit and a high stop period. Frame timing comes from an internal baud generator. It produces one tick every 2 × (1 + divisor) system clock cycles, and each bit time is 32 such ticks.

The stop period is set in steps of one eighth of a bit, so a link can be tuned between a very short guard time and two full stop bits. A break control holds the line low for as long as it is set, whatever the frame engine is doing. The baud generator has its own enable. While it is low, a frame in progress freezes where it stands. The whole frame format is captured when a character is accepted, so software can stage the next setting while a frame is still on the wire.

Top module: `serial_tx_engine`

## Requirements
- R1: After reset, and whenever no frame is in progress and break is low, `tx_line` is 1, `tx_ready` is 1 and `tx_busy` is 0.
- R2: Each start, data and parity bit lasts exactly 32 × 2 × (1 + `baud_div`) system clock cycles. The frame begins at the clock edge that accepts the character.
- R3: A frame starts with one start bit at 0, followed by the data bits least significant bit first.
- R4: `char_len` value 0, 1, 2 or 3 selects 5, 6, 7 or 8 data bits, taken from `tx_data[4:0]` up to `tx_data[7:0]`. Higher data bits are not sent.
- R5: When `par_en` is 1, one parity bit follows the last data bit. When `par_even` is 1 it makes the count of ones in data plus parity even; when `par_even` is 0 it makes that count odd. When `par_en` is 0, no parity bit is sent.
- R6: The stop period is at 1 and lasts (`stop_len` + 1) × 4 baud ticks, so 0 gives one eighth of a bit and 15 gives two bits. `tx_ready` returns to 1 at the edge where the stop period ends.
- R7: While `brk` is 1, `tx_line` is 0 in every state. Break does not start, stop or alter a frame.
- R8: While `baud_en` is 0 the baud generator produces no ticks, and a frame in progress holds its current bit and state.
- R9: `char_len`, `par_en`, `par_even` and `stop_len` are captured when a character is accepted. Changes to them during a frame have no effect on that frame.
- R10: A character is accepted on a clock edge where `tx_valid` and `tx_ready` are both 1. From that edge until the frame ends, `tx_ready` is 0 and `tx_busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_en | input | 1 | Baud generator enable |
| baud_div | input | 16 | Divisor; tick period is 2 × (1 + value) clocks |
| char_len | input | 2 | Data bit count code (0..3 for 5..8 bits) |
| par_en | input | 1 | Parity bit enable |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| stop_len | input | 4 | Stop period in eighths of a bit, minus one |
| brk | input | 1 | Force the line low while set |
| tx_valid | input | 1 | Character offered |
| tx_data | input | 8 | Character to send |
| tx_ready | output | 1 | Engine idle, will accept a character |
| tx_line | output | 1 | Serial output line, idles high |
| tx_busy | output | 1 | Frame in progress |

## Verification
The assertions assume that `baud_div` does not change while a frame is on the line, and that `rst_n` is held low for at least one clock edge before the first check. The directed tasks change the divisor only between frames and keep reset low for several cycles. They also deliberately scramble the frame-format inputs right after each character is accepted, so that the captured-configuration property is exercised on every frame. Break and baud-enable are toggled only at points where the bench has already computed what the line must show.

// File: rtl/stx_pkg.sv
`timescale 1ns/1ps
package stx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } stx_state_e;

  typedef struct packed {
    logic [1:0] len_code;
    logic       par_en;
    logic       par_even;
    logic [3:0] stop_eighths;
  } stx_cfg_t;

  // Mask of the data bits that belong to a character of the coded length.
  function automatic logic [7:0] char_mask(input logic [1:0] code);
    return 8'hFF >> (2'd3 - code);
  endfunction

  // Index of the last data bit sent for a coded length (4..7).
  function automatic logic [2:0] last_index(input logic [1:0] code);
    return 3'd4 + {1'b0, code};
  endfunction

  // Parity bit value for the masked character.
  function automatic logic par_bit(input logic [7:0] d, input logic [1:0] code,
                                   input logic even);
    logic ones_odd;
    ones_odd = ^(d & char_mask(code));
    return even ? ones_odd : ~ones_odd;
  endfunction

endpackage

// File: rtl/stx_baud_gen.sv
`timescale 1ns/1ps
module stx_baud_gen #(
  parameter int BW_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            restart,
  input  logic [BW_W-1:0] divisor,
  output logic            tick
);
  localparam int CNT_W = BW_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_last;

  // Period of 2*(1+divisor) clocks: terminal count is 2*divisor+1.
  assign cnt_last = {divisor, 1'b1};
  assign tick     = en && !restart && (cnt >= cnt_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!en || restart || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // Period is at least two clocks, so ticks never come back to back.
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // No tick is ever produced while the generator is disabled.
  p_quiet_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && $past(!en)) |-> (cnt == '0));

endmodule

// File: rtl/stx_frame.sv
`timescale 1ns/1ps
module stx_frame
  import stx_pkg::*;
#(
  parameter int OVS = 32
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     req_valid,
  input  logic [7:0] req_data,
  input  stx_cfg_t req_cfg,
  input  logic     brk,
  output logic     accept,
  output logic     ready,
  output logic     busy,
  output logic     line
);
  localparam int STOP_UNIT = OVS / 8;
  localparam int TCNT_W    = $clog2(2 * OVS);
  localparam logic [TCNT_W-1:0] BIT_LAST = TCNT_W'(OVS - 1);

  stx_state_e        state;
  logic [TCNT_W-1:0] tcnt;
  logic [TCNT_W-1:0] seg_last;
  logic [2:0]        bidx;
  logic [7:0]        shreg;
  stx_cfg_t          cfg_q;
  logic              par_q;
  logic              seg_end;
  logic              last_data;
  logic              frame_level;

  assign ready  = (state == ST_IDLE);
  assign busy   = !ready;
  assign accept = req_valid && ready;

  // Segment length in ticks: one bit, or the stop period in eighths.
  always_comb begin
    if (state == ST_STOP)
      seg_last = TCNT_W'((int'(cfg_q.stop_eighths) + 1) * STOP_UNIT - 1);
    else
      seg_last = BIT_LAST;
  end

  assign seg_end   = tick && (state != ST_IDLE) && (tcnt == seg_last);
  assign last_data = (bidx == last_index(cfg_q.len_code));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      tcnt  <= '0;
      bidx  <= '0;
      shreg <= '0;
      cfg_q <= '0;
      par_q <= 1'b0;
    end else if (accept) begin
      state <= ST_START;
      tcnt  <= '0;
      bidx  <= '0;
      shreg <= req_data & char_mask(req_cfg.len_code);
      cfg_q <= req_cfg;
      par_q <= par_bit(req_data, req_cfg.len_code, req_cfg.par_even);
    end else if (tick && (state != ST_IDLE)) begin
      if (seg_end) begin
        tcnt <= '0;
        case (state)
          ST_START: state <= ST_DATA;
          ST_DATA: begin
            if (last_data) begin
              state <= cfg_q.par_en ? ST_PAR : ST_STOP;
            end else begin
              bidx  <= bidx + 1'b1;
              shreg <= {1'b0, shreg[7:1]};
            end
          end
          ST_PAR:  state <= ST_STOP;
          default: state <= ST_IDLE;
        endcase
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  always_comb begin
    case (state)
      ST_START: frame_level = 1'b0;
      ST_DATA:  frame_level = shreg[0];
      ST_PAR:   frame_level = par_q;
      default:  frame_level = 1'b1;
    endcase
  end

  assign line = brk ? 1'b0 : frame_level;

  p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (brk || !line));

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !brk) |-> line);

  p_stop_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_STOP) && !brk) |-> line);

  p_stop_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_STOP) && seg_end) |=> ready);

  p_data_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA) |-> (bidx <= last_index(cfg_q.len_code)));

  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cfg_q));

  p_no_parity_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PAR) |-> cfg_q.par_en);

endmodule

// File: rtl/serial_tx_engine.sv
`timescale 1ns/1ps
module serial_tx_engine
  import stx_pkg::*;
#(
  parameter int BW_W = 16,
  parameter int OVS  = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            baud_en,
  input  logic [BW_W-1:0] baud_div,
  input  logic [1:0]      char_len,
  input  logic            par_en,
  input  logic            par_even,
  input  logic [3:0]      stop_len,
  input  logic            brk,
  input  logic            tx_valid,
  input  logic [7:0]      tx_data,
  output logic            tx_ready,
  output logic            tx_line,
  output logic            tx_busy
);
  stx_cfg_t cfg_in;
  logic     baud_tick;
  logic     frame_accept;

  assign cfg_in = '{len_code: char_len, par_en: par_en,
                    par_even: par_even, stop_eighths: stop_len};

  stx_baud_gen #(.BW_W(BW_W)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (baud_en),
    .restart (frame_accept),
    .divisor (baud_div),
    .tick    (baud_tick)
  );

  stx_frame #(.OVS(OVS)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (baud_tick),
    .req_valid (tx_valid),
    .req_data  (tx_data),
    .req_cfg   (cfg_in),
    .brk       (brk),
    .accept    (frame_accept),
    .ready     (tx_ready),
    .busy      (tx_busy),
    .line      (tx_line)
  );

  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !baud_en) |=> tx_busy);

  p_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (tx_busy && !tx_ready));

endmodule

// File: tb/serial_tx_engine_tb.sv
`timescale 1ns/1ps
module serial_tx_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        baud_en = 1'b1;
  logic [15:0] baud_div = '0;
  logic [1:0]  char_len = '0;
  logic        par_en = 1'b0;
  logic        par_even = 1'b0;
  logic [3:0]  stop_len = '0;
  logic        brk = 1'b0;
  logic        tx_valid = 1'b0;
  logic [7:0]  tx_data = '0;
  logic        tx_ready;
  logic        tx_line;
  logic        tx_busy;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  serial_tx_engine u_dut (
    .clk(clk), .rst_n(rst_n), .baud_en(baud_en), .baud_div(baud_div),
    .char_len(char_len), .par_en(par_en), .par_even(par_even),
    .stop_len(stop_len), .brk(brk), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .tx_line(tx_line), .tx_busy(tx_busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Offer one character, scramble the format inputs after acceptance and
  // check every bit at its midpoint plus the exact end of the stop period.
  task automatic send_frame(input logic [7:0] d, input int code, input bit pe,
                            input bit pev, input int s, input int bw,
                            input string req);
    int p;
    int n;
    int nb;
    int ones;
    int elapsed;
    int stop_t;
    logic exp_bits [0:10];
    p = 2 * (bw + 1);
    n = code + 5;
    @(negedge clk);
    baud_div = 16'(bw); char_len = 2'(code); par_en = pe; par_even = pev;
    stop_len = 4'(s); tx_data = d; tx_valid = 1'b1;
    @(posedge clk); #1;
    tx_valid = 1'b0;
    // R9: new format values during the frame must not matter
    char_len = ~2'(code); par_en = ~pe; par_even = ~pev; stop_len = ~4'(s);
    chk(tx_busy && !tx_ready, "R10 busy after accept", int'(tx_busy), 1);
    exp_bits[0] = 1'b0;
    ones = 0;
    for (int i = 0; i < n; i++) begin
      exp_bits[1 + i] = d[i];
      ones += int'(d[i]);
    end
    if (pe) exp_bits[n + 1] = pev ? logic'(ones % 2) : logic'(1 - ones % 2);
    nb = 1 + n + int'(pe);
    wait_edges(16 * p);
    elapsed = 16 * p;
    chk(tx_line == 1'b0, {req, " R3 start bit"}, int'(tx_line), 0);
    for (int i = 1; i < nb; i++) begin
      wait_edges(32 * p);
      elapsed += 32 * p;
      if (pe && i == nb - 1)
        chk(tx_line == exp_bits[i], {req, " R5 parity bit"}, int'(tx_line), int'(exp_bits[i]));
      else
        chk(tx_line == exp_bits[i], {req, " R3 R4 data bit"}, int'(tx_line), int'(exp_bits[i]));
    end
    stop_t = 4 * (s + 1) * p;
    wait_edges(32 * p * nb - elapsed + stop_t / 2);
    elapsed = 32 * p * nb + stop_t / 2;
    chk(tx_line == 1'b1, {req, " R6 stop level"}, int'(tx_line), 1);
    wait_edges(32 * p * nb + stop_t - 1 - elapsed);
    chk(tx_busy == 1'b1, {req, " R6 R2 busy until stop ends"}, int'(tx_busy), 1);
    wait_edges(1);
    chk(tx_ready == 1'b1 && tx_line == 1'b1, {req, " R6 R2 ready at stop end"},
        int'(tx_ready), 1);
  endtask

  task automatic wait_ready(input int limit);
    for (int i = 0; i < limit; i++) begin
      if (tx_ready) break;
      wait_edges(1);
    end
  endtask

  task automatic test_reset;
    chk(tx_line == 1'b1, "R1 reset line", int'(tx_line), 1);
    chk(tx_ready == 1'b1, "R1 reset ready", int'(tx_ready), 1);
    chk(tx_busy == 1'b0, "R1 reset busy", int'(tx_busy), 0);
  endtask

  task automatic test_break_idle;
    @(negedge clk); brk = 1'b1;
    wait_edges(3);
    chk(tx_line == 1'b0, "R7 break while idle", int'(tx_line), 0);
    chk(tx_ready == 1'b1, "R7 break starts no frame", int'(tx_ready), 1);
    @(negedge clk); brk = 1'b0;
    wait_edges(1);
    chk(tx_line == 1'b1, "R7 line back high after break", int'(tx_line), 1);
  endtask

  task automatic test_break_frame;
    // 8 data bits of all ones, divisor 0 (2 clocks per tick)
    @(negedge clk);
    baud_div = 16'd0; char_len = 2'd3; par_en = 1'b0; stop_len = 4'd7;
    tx_data = 8'hFF; tx_valid = 1'b1;
    @(posedge clk); #1;
    tx_valid = 1'b0;
    wait_edges(16 * 2 + 32 * 2 * 2);
    chk(tx_line == 1'b1, "R3 data bit before break", int'(tx_line), 1);
    brk = 1'b1;
    wait_edges(1);
    chk(tx_line == 1'b0, "R7 break forces data bit low", int'(tx_line), 0);
    brk = 1'b0;
    wait_edges(1);
    chk(tx_line == 1'b1, "R7 frame continues after break", int'(tx_line), 1);
    // remaining: frame total 9*64+32*2 = 640 clocks from accept
    wait_edges(640 - (32 + 128 + 2) - 1);
    chk(tx_busy == 1'b1, "R7 break did not shorten frame", int'(tx_busy), 1);
    wait_edges(1);
    chk(tx_ready == 1'b1, "R7 break did not stretch frame", int'(tx_ready), 1);
  endtask

  task automatic test_stall;
    @(negedge clk);
    baud_en = 1'b0; baud_div = 16'd0; char_len = 2'd0; par_en = 1'b0;
    stop_len = 4'd0; tx_data = 8'h1F; tx_valid = 1'b1;
    @(posedge clk); #1;
    tx_valid = 1'b0;
    wait_edges(500);
    chk(tx_busy == 1'b1, "R8 frame held while baud off", int'(tx_busy), 1);
    chk(tx_line == 1'b0, "R8 start bit held while baud off", int'(tx_line), 0);
    baud_en = 1'b1;
    // start bit restarts its count: 6 bits of 64 clocks plus 8 stop clocks
    wait_edges(6 * 64 + 8 - 1);
    chk(tx_busy == 1'b1, "R8 resumed frame length", int'(tx_busy), 1);
    wait_edges(1);
    chk(tx_ready == 1'b1, "R8 resumed frame ends", int'(tx_ready), 1);
    wait_ready(100);
  endtask

  initial begin
    wait_edges(200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    wait_edges(5);
    test_reset();
    rst_n = 1'b1;
    wait_edges(3);
    test_reset();
    send_frame(8'hA5, 3, 1'b0, 1'b0, 7, 0, "8N one stop");
    send_frame(8'hEB, 0, 1'b1, 1'b1, 7, 1, "5E even parity");
    send_frame(8'h53, 2, 1'b1, 1'b0, 3, 0, "7O odd parity");
    send_frame(8'h00, 2, 1'b1, 1'b0, 7, 0, "7O zero char");
    send_frame(8'hC6, 1, 1'b0, 1'b0, 0, 0, "6N eighth stop");
    send_frame(8'h3C, 3, 1'b1, 1'b1, 15, 2, "8E two stops div2");
    test_break_idle();
    test_break_frame();
    test_stall();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule